// File: doc/BRIEF.md
# Tone Generator Register Port and Period Scaler

This block is the write side of a three-voice sound unit with two pulse voices and one ramp (sawtooth) voice. It receives single-cycle byte writes from a host CPU on a 16-bit address bus and decodes them into per-voice register banks. Each bank holds a control byte, a 12-bit oscillator period and an enable bit. A global register on the first bank holds three flags: freeze, 16x speed-up and 256x speed-up.

The block drives the voice generators downstream. Each voice gets its decoded control fields, its enable and an effective period. The effective period is the raw 12-bit period shifted right by the global speed-up setting. A single freeze line, when set, tells every oscillator to stop in its present state without resetting. A static strap input exchanges the two lowest address lines, for boards wired with those lines crossed. The block has no read-back and produces no audio.

Top module: `tone_reg_port`

## Requirements
- R1: After reset every output is zero: all voices are disabled, all periods and control fields are 0, and freeze is clear.
- R2: Address bits 15:12 select the bank: 0x9 is pulse voice 1, 0xA is pulse voice 2 and 0xB is the ramp voice. A write to any other bank value changes nothing. Address bits 11:2 are not decoded, so bank addresses mirror.
- R3: Offset 0 is the control byte. For a pulse voice, bit 7 is constant-level mode, bits 6:4 are duty and bits 3:0 are volume. For the ramp voice, bits 5:0 are the accumulate rate and bits 7:6 are ignored.
- R4: Offset 1 loads period bits 7:0. Offset 2 loads period bits 11:8 from data bits 3:0 and loads the voice enable from data bit 7. Data bits 6:4 at offset 2 are ignored.
- R5: Offset 3 of bank 0x9 is the global register: bit 0 is freeze, bit 1 is 16x and bit 2 is 256x. Offset 3 of banks 0xA and 0xB is ignored.
- R6: With freeze clear, 16x set and 256x clear, every voice's effective period equals its raw period shifted right by 4.
- R7: With freeze clear and 256x set, every voice's effective period equals its raw period shifted right by 8, whatever the 16x bit is.
- R8: With freeze set, the freeze output is 1 and every effective period equals the raw period, whatever the other two flags are.
- R9: With the swap strap at 1, address bits 0 and 1 are exchanged before decoding. Offset 1 then loads the high period bits and enable, and offset 2 loads the low period bits. Offsets 0 and 3 keep their meaning.
- R10: A write shows at the outputs after the clock edge that samples the strobe. Cycles with the strobe low change nothing, whatever is on the address and data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_swap | input | 1 | Strap: 1 exchanges address bits 0 and 1 |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| freeze | output | 1 | Global freeze for all oscillators |
| p1_volume | output | 4 | Pulse 1 volume |
| p1_duty | output | 3 | Pulse 1 duty |
| p1_const | output | 1 | Pulse 1 constant-level mode |
| p1_enable | output | 1 | Pulse 1 enable |
| p1_period | output | 12 | Pulse 1 effective period |
| p2_volume | output | 4 | Pulse 2 volume |
| p2_duty | output | 3 | Pulse 2 duty |
| p2_const | output | 1 | Pulse 2 constant-level mode |
| p2_enable | output | 1 | Pulse 2 enable |
| p2_period | output | 12 | Pulse 2 effective period |
| ramp_rate | output | 6 | Ramp accumulate rate |
| ramp_enable | output | 1 | Ramp enable |
| ramp_period | output | 12 | Ramp effective period |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 12-bit period, a first bank code of 0x9 and shift amounts of 4 and 8. These values put all three banks, the unmapped bank codes on either side of them and the mirrored addresses within reach of plain directed writes. The raw periods are chosen so that the 4-bit and 8-bit shifts give values that differ from each other and from the unshifted period. The bench runs with the swap strap at 0 and then at 1, so both decode orders of offsets 1 and 2 are compared against one register model.

// File: rtl/tone_reg_pkg.sv
package tone_reg_pkg;

  typedef enum logic [1:0] {
    SCL_X1   = 2'd0,
    SCL_X16  = 2'd1,
    SCL_X256 = 2'd2,
    SCL_HALT = 2'd3
  } scale_e;

  typedef enum logic [1:0] {
    OFS_CTRL   = 2'd0,
    OFS_LO     = 2'd1,
    OFS_HI     = 2'd2,
    OFS_GLOBAL = 2'd3
  } ofs_e;

  // freeze beats 256x, 256x beats 16x
  function automatic scale_e pick_scale(input logic frz, input logic x16, input logic x256);
    if (frz)       return SCL_HALT;
    else if (x256) return SCL_X256;
    else if (x16)  return SCL_X16;
    else           return SCL_X1;
  endfunction

endpackage

// File: rtl/tone_addr_dec.sv
module tone_addr_dec
  import tone_reg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_CH    = 3,
  parameter int BANK_W    = 4,
  parameter int BANK_BASE = 9,
  parameter int GLB_CH    = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              swap,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic              glb_we
);
  localparam int BANK_LSB = ADDR_W - BANK_W;

  logic [BANK_W-1:0] bank;
  logic [1:0]        ofs_raw;
  ofs_e              ofs;

  assign bank    = wr_addr[ADDR_W-1:BANK_LSB];
  assign ofs_raw = wr_addr[1:0];

  always_comb begin
    if (swap) ofs = ofs_e'({ofs_raw[0], ofs_raw[1]});
    else      ofs = ofs_e'(ofs_raw);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    logic hit;
    assign hit         = wr_en && (bank == BANK_W'(BANK_BASE + ch));
    assign ctrl_we[ch] = hit && (ofs == OFS_CTRL);
    assign lo_we[ch]   = hit && (ofs == OFS_LO);
    assign hi_we[ch]   = hit && (ofs == OFS_HI);
  end

  assign glb_we = wr_en && (bank == BANK_W'(BANK_BASE + GLB_CH)) && (ofs == OFS_GLOBAL);

endmodule

// File: rtl/tone_chan_regs.sv
module tone_chan_regs #(
  parameter int DATA_W = 8,
  parameter int PER_W  = 12,
  parameter int EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [PER_W-1:0]  period_q,
  output logic              en_q
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = PER_W - LO_W;

  logic [DATA_W-1:0] ctrl_d;
  logic [PER_W-1:0]  period_d;
  logic              en_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    period_d = period_q;
    en_d     = en_q;
    if (ctrl_we) ctrl_d = wdata;
    if (lo_we)   period_d[LO_W-1:0] = wdata;
    if (hi_we) begin
      period_d[PER_W-1:LO_W] = wdata[HI_W-1:0];
      en_d                   = wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      en_q     <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      en_q     <= en_d;
    end
  end

  // R10: no write enable, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_we || lo_we || hi_we) |=> ($stable(ctrl_q) && $stable(period_q) && $stable(en_q)));

endmodule

// File: rtl/tone_period_scale.sv
module tone_period_scale
  import tone_reg_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int PER_W  = 12,
  parameter int DATA_W = 8,
  parameter int SH_MID = 4,
  parameter int SH_TOP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_we,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_CH*PER_W-1:0] period_raw,
  output logic                    freeze,
  output logic [NUM_CH*PER_W-1:0] period_eff
);
  localparam int FLAG_W = 3;

  logic [FLAG_W-1:0] flags_q, flags_d;
  scale_e            mode;

  always_comb begin
    flags_d = flags_q;
    if (glb_we) flags_d = wdata[FLAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign mode   = pick_scale(flags_q[0], flags_q[1], flags_q[2]);
  assign freeze = (mode == SCL_HALT);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
    logic [PER_W-1:0] raw, eff;
    assign raw = period_raw[ch*PER_W +: PER_W];
    always_comb begin
      case (mode)
        SCL_X16:  eff = raw >> SH_MID;
        SCL_X256: eff = raw >> SH_TOP;
        default:  eff = raw;
      endcase
    end
    assign period_eff[ch*PER_W +: PER_W] = eff;

    // R6
    p_mid_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q[0] && flags_q[1] && !flags_q[2]) |-> (period_eff[ch*PER_W +: PER_W] == (raw >> SH_MID)));
    // R7
    p_top_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q[0] && flags_q[2]) |-> (period_eff[ch*PER_W +: PER_W] == (raw >> SH_TOP)));
    // R8
    p_freeze_unscaled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[0] |-> (freeze && (period_eff[ch*PER_W +: PER_W] == raw)));
  end

  // R5
  p_flag_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    glb_we |=> (freeze == $past(wdata[0])));

endmodule

// File: rtl/tone_reg_port.sv
module tone_reg_port
  import tone_reg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_BASE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_swap,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              freeze,
  output logic [3:0]        p1_volume,
  output logic [2:0]        p1_duty,
  output logic              p1_const,
  output logic              p1_enable,
  output logic [11:0]       p1_period,
  output logic [3:0]        p2_volume,
  output logic [2:0]        p2_duty,
  output logic              p2_const,
  output logic              p2_enable,
  output logic [11:0]       p2_period,
  output logic [5:0]        ramp_rate,
  output logic              ramp_enable,
  output logic [11:0]       ramp_period
);
  localparam int NUM_CH  = 3;
  localparam int DATA_W  = 8;
  localparam int PER_W   = 12;
  localparam int BANK_W  = 4;
  localparam int CH_P1   = 0;
  localparam int CH_P2   = 1;
  localparam int CH_RAMP = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0]       ctrl_we, lo_we, hi_we;
  logic                    glb_we;
  logic [DATA_W-1:0]       ctrl_q [NUM_CH];
  logic [NUM_CH-1:0]       en_q;
  logic [NUM_CH*PER_W-1:0] period_raw, period_eff;

  tone_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BANK_W(BANK_W),
    .BANK_BASE(BANK_BASE), .GLB_CH(CH_P1)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .swap(addr_swap),
    .ctrl_we(ctrl_we), .lo_we(lo_we), .hi_we(hi_we), .glb_we(glb_we)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [PER_W-1:0] per_q;
    tone_chan_regs #(.DATA_W(DATA_W), .PER_W(PER_W), .EN_BIT(7)) u_regs (
      .clk(clk), .rst_n(rst_sync_n),
      .ctrl_we(ctrl_we[ch]), .lo_we(lo_we[ch]), .hi_we(hi_we[ch]),
      .wdata(wr_data),
      .ctrl_q(ctrl_q[ch]), .period_q(per_q), .en_q(en_q[ch])
    );
    assign period_raw[ch*PER_W +: PER_W] = per_q;
  end

  tone_period_scale #(
    .NUM_CH(NUM_CH), .PER_W(PER_W), .DATA_W(DATA_W), .SH_MID(4), .SH_TOP(8)
  ) u_scale (
    .clk(clk), .rst_n(rst_sync_n), .glb_we(glb_we), .wdata(wr_data),
    .period_raw(period_raw), .freeze(freeze), .period_eff(period_eff)
  );

  assign p1_const    = ctrl_q[CH_P1][7];
  assign p1_duty     = ctrl_q[CH_P1][6:4];
  assign p1_volume   = ctrl_q[CH_P1][3:0];
  assign p1_enable   = en_q[CH_P1];
  assign p1_period   = period_eff[CH_P1*PER_W +: PER_W];
  assign p2_const    = ctrl_q[CH_P2][7];
  assign p2_duty     = ctrl_q[CH_P2][6:4];
  assign p2_volume   = ctrl_q[CH_P2][3:0];
  assign p2_enable   = en_q[CH_P2];
  assign p2_period   = period_eff[CH_P2*PER_W +: PER_W];
  assign ramp_rate   = ctrl_q[CH_RAMP][5:0];
  assign ramp_enable = en_q[CH_RAMP];
  assign ramp_period = period_eff[CH_RAMP*PER_W +: PER_W];

  logic [BANK_W-1:0] bank_in;
  logic              bank_mapped;
  assign bank_in     = wr_addr[ADDR_W-1:ADDR_W-BANK_W];
  assign bank_mapped = (bank_in >= BANK_W'(BANK_BASE)) && (bank_in < BANK_W'(BANK_BASE + NUM_CH));

  // R2: at most one register written per strobe
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ctrl_we, lo_we, hi_we, glb_we}));
  // R2: unmapped banks leave state alone
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !bank_mapped) |=> ($stable(period_raw) && $stable(en_q) && $stable(freeze)));
  // R3
  p_ctrl_fields_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && bank_in == BANK_W'(BANK_BASE) && wr_addr[1:0] == 2'd0)
      |=> (p1_volume == $past(wr_data[3:0]) && p1_duty == $past(wr_data[6:4])));
  // R4
  p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !addr_swap && bank_in == BANK_W'(BANK_BASE) && wr_addr[1:0] == 2'd1)
      |=> (period_raw[7:0] == $past(wr_data)));
  // R9
  p_swap_lo_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr_swap && bank_in == BANK_W'(BANK_BASE) && wr_addr[1:0] == 2'd2)
      |=> (period_raw[7:0] == $past(wr_data)));

endmodule

// File: tb/tone_reg_port_tb.sv
module tone_reg_port_tb;
  typedef logic [61:0] snap_t;

  logic        clk = 1'b0;
  logic        rst_n, addr_swap, wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        freeze;
  logic [3:0]  p1_volume, p2_volume;
  logic [2:0]  p1_duty, p2_duty;
  logic        p1_const, p1_enable, p2_const, p2_enable, ramp_enable;
  logic [11:0] p1_period, p2_period, ramp_period;
  logic [5:0]  ramp_rate;

  always #2 clk = ~clk;

  tone_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr_swap(addr_swap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .freeze(freeze),
    .p1_volume(p1_volume), .p1_duty(p1_duty), .p1_const(p1_const),
    .p1_enable(p1_enable), .p1_period(p1_period),
    .p2_volume(p2_volume), .p2_duty(p2_duty), .p2_const(p2_const),
    .p2_enable(p2_enable), .p2_period(p2_period),
    .ramp_rate(ramp_rate), .ramp_enable(ramp_enable), .ramp_period(ramp_period)
  );

  // reference model, written from the requirements
  logic [7:0]  m_ctrl [3];
  logic [11:0] m_per  [3];
  logic        m_en   [3];
  logic [2:0]  m_flag;

  snap_t exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_bad = 0;
  bit    done  = 0;

  function automatic logic [11:0] eff(input logic [11:0] p);
    if (m_flag[0])      return p;
    else if (m_flag[2]) return p >> 8;
    else if (m_flag[1]) return p >> 4;
    else                return p;
  endfunction

  function automatic snap_t model_snap();
    return {m_flag[0],
            m_ctrl[0][3:0], m_ctrl[0][6:4], m_ctrl[0][7], m_en[0], eff(m_per[0]),
            m_ctrl[1][3:0], m_ctrl[1][6:4], m_ctrl[1][7], m_en[1], eff(m_per[1]),
            m_ctrl[2][5:0], m_en[2], eff(m_per[2])};
  endfunction

  function automatic snap_t dut_snap();
    return {freeze, p1_volume, p1_duty, p1_const, p1_enable, p1_period,
            p2_volume, p2_duty, p2_const, p2_enable, p2_period,
            ramp_rate, ramp_enable, ramp_period};
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] bank;
    logic [1:0] ofs;
    int ch;
    bank = a[15:12];
    ofs  = addr_swap ? {a[0], a[1]} : a[1:0];
    if (bank < 4'h9 || bank > 4'hB) return;
    ch = int'(bank) - 9;
    case (ofs)
      2'd0: m_ctrl[ch] = d;
      2'd1: m_per[ch][7:0] = d;
      2'd2: begin m_per[ch][11:8] = d[3:0]; m_en[ch] = d[7]; end
      default: if (ch == 0) m_flag = d[2:0];
    endcase
  endtask

  // driver: one bus cycle, then push the expected state
  task automatic drive(input logic we, input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (we) model_write(a, d);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
  endtask

  // monitor: compares one item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        snap_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = dut_snap();
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_swap = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 3; i++) begin m_ctrl[i] = '0; m_per[i] = '0; m_en[i] = 1'b0; end
    m_flag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.push_back(model_snap()); tag_q.push_back("R1 reset state");

    drive(1, 16'h9000, 8'hB5, "R3 pulse1 control fields");
    drive(1, 16'h9001, 8'h34, "R4 pulse1 low period");
    drive(1, 16'h9002, 8'hFA, "R4 pulse1 high period and enable");
    drive(1, 16'hA000, 8'h4C, "R3 pulse2 control fields");
    drive(1, 16'hA001, 8'hC7, "R4 pulse2 low period");
    drive(1, 16'hA002, 8'h85, "R4 pulse2 high period");
    drive(1, 16'hB000, 8'hFF, "R3 ramp rate masks bits 7:6");
    drive(1, 16'hB001, 8'h9E, "R4 ramp low period");
    drive(1, 16'hB002, 8'h83, "R4 ramp high period");
    drive(1, 16'h8001, 8'h55, "R2 bank below range ignored");
    drive(1, 16'hC002, 8'h00, "R2 bank above range ignored");
    drive(1, 16'h9FF1, 8'h6A, "R2 mirrored low period write");
    drive(1, 16'hA003, 8'h07, "R5 offset 3 on pulse2 ignored");
    drive(1, 16'hB003, 8'h01, "R5 offset 3 on ramp ignored");
    drive(0, 16'h9001, 8'h00, "R10 strobe low no change");
    drive(0, 16'h9003, 8'h01, "R10 strobe low no freeze");
    drive(1, 16'h9003, 8'h02, "R6 16x shift");
    drive(1, 16'h9003, 8'h04, "R7 256x shift");
    drive(1, 16'h9003, 8'h06, "R7 256x beats 16x");
    drive(1, 16'h9003, 8'h07, "R8 freeze beats both");
    drive(1, 16'h9003, 8'h03, "R8 freeze with 16x");
    drive(1, 16'h9003, 8'h00, "R5 global clear");

    @(negedge clk); addr_swap = 1'b1;
    drive(1, 16'h9001, 8'h0F, "R9 swapped offset 1 loads high and enable");
    drive(1, 16'h9002, 8'hD2, "R9 swapped offset 2 loads low");
    drive(1, 16'hA001, 8'h81, "R9 swapped pulse2 high");
    drive(1, 16'h9000, 8'h27, "R9 offset 0 unchanged under swap");
    drive(1, 16'h9003, 8'h02, "R9 offset 3 unchanged under swap");
    drive(0, 16'hB002, 8'hFF, "R10 strobe low under swap");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule